// File: doc/BRIEF.md
# Digital IQ Frequency Modulator

This block shifts a stream of signed I/Q sample pairs in frequency. It multiplies each pair by a simple digital carrier whose frequency is a fixed fraction of the sample rate at its own input. It sits after the interpolation chain and before the converters. The carrier sequences contain only +1, 0 and -1, so the datapath needs no multiplier. The only operations are sign changes, forcing to zero, and swapping the two channels. Every negation saturates.

A small configuration register sets three things. The first is the carrier rate: none, half the input rate, or a quarter of the input rate. The second chooses real modulation, where each channel is treated on its own, or complex image-reject modulation, where I and Q are rotated together. The third is the direction of that rotation. Complex mode applies only at the quarter rate. At any other rate a complex request falls back to real behaviour. The carrier phase advances once per accepted sample. It restarts at phase 0 after reset and after any write that changes the configuration. Results appear one clock after the sample is accepted.

Top module: `iq_carrier_mixer`

## Requirements
- R1: After reset, out_valid and both outputs are 0. The configuration is rate code 10 (quarter rate), real mode (cfg_real_in=1) and rotation bit 0, and the carrier phase is 0.
- R2: With rate code 00, every accepted pair is passed to the outputs unchanged.
- R3: With rate code 01, the outputs alternate between (I,Q) and (-I,-Q), starting with (I,Q) at phase 0. This holds in either mode.
- R4: With rate code 10 or 11 in real mode, the outputs follow the phase sequence (I,Q), (0,0), (-I,-Q), (0,0).
- R5: With rate code 10 or 11, complex mode (cfg_real_in=0) and rotation bit 0, the outputs over phases 0 to 3 are (I,Q), (Q,-I), (-I,-Q), (-Q,I).
- R6: With rotation bit 1 in complex quarter-rate mode, phases 1 and 3 become (-Q,I) and (Q,-I). Phases 0 and 2 are the same as in R5.
- R7: Complex mode with rate code 00 or 01 behaves exactly like real mode at that rate.
- R8: Negating the most negative code (-8192) gives +8191. No output is ever -8192 unless an input pair holds -8192.
- R9: out_valid equals in_valid delayed by one clock. The phase advances by one (modulo 4) on each accepted sample only. When in_valid is low, the outputs hold their last values and the data inputs are ignored.
- R10: A configuration write (cfg_we high) whose value differs from the stored one resets the phase to 0. A write of the stored value leaves the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rate_in | input | 2 | Carrier rate code: 00 none, 01 half rate, 1x quarter rate |
| cfg_real_in | input | 1 | 1 = real modulation, 0 = complex image-reject |
| cfg_flip_in | input | 1 | Rotation direction: 0 = e^-jw, 1 = e^+jw |
| in_valid | input | 1 | Input pair strobe |
| in_i | input | 14 | Signed I sample |
| in_q | input | 14 | Signed Q sample |
| out_valid | output | 1 | Output pair strobe |
| out_i | output | 14 | Signed modulated I |
| out_q | output | 14 | Signed modulated Q |

## Verification
The bench drives -8192 through every negating route. A design that wrapped the negation would emit -8192 where +8191 is due. It checks that a complex request at the half and zero rates falls back to the real routes. A design that ignored the fallback would swap the channels there. It rewrites an unchanged configuration in the middle of a carrier cycle, then a changed value that behaves identically (code 11 instead of 10). A counter that restarted on every write, or on none, would shift the whole following sequence. Idle gaps filled with junk data catch a phase that advances without valid samples, or outputs that follow ignored inputs.

// File: rtl/iqmix_pkg.sv
// Shared types for the IQ carrier mixer: rate codes, configuration word
// and the per-sample routing choices the carrier sequence implies.
package iqmix_pkg;

    typedef enum logic [1:0] {
        RATE_OFF   = 2'b00,
        RATE_HALF  = 2'b01,
        RATE_QTR   = 2'b10,
        RATE_QTR_B = 2'b11
    } rate_e;

    typedef struct packed {
        rate_e rate;
        logic  real_mode;
        logic  flip;
    } mix_cfg_t;

    localparam mix_cfg_t CFG_RESET = '{rate: RATE_QTR, real_mode: 1'b1, flip: 1'b0};

    // Output pair selection: PASS (I,Q), NEG (-I,-Q), ZERO (0,0),
    // QNI (Q,-I), NQI (-Q,I).
    typedef enum logic [2:0] {
        RT_PASS = 3'd0,
        RT_NEG  = 3'd1,
        RT_ZERO = 3'd2,
        RT_QNI  = 3'd3,
        RT_NQI  = 3'd4
    } route_e;

    localparam int PHASE_W = 2;

endpackage

// File: rtl/iqmix_cfg_reg.sv
// Configuration holding register.
// Assumes: writes are single-cycle strobes; restart is combinational so the
// phase counter can clear on the same edge that stores a changed value.
module iqmix_cfg_reg
    import iqmix_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  mix_cfg_t wdata,
    output mix_cfg_t cfg_q,
    output logic     restart
);

    // Flag a write that alters the stored configuration.
    always_comb begin
        restart = we && (wdata != cfg_q);
    end

    // Store the configuration; reset loads the defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end

endmodule

// File: rtl/iqmix_phase.sv
// Carrier phase counter, one step per accepted sample, modulo 4.
// Assumes: restart has priority over advance.
module iqmix_phase
    import iqmix_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               advance,
    output logic [PHASE_W-1:0] phase_q
);

    // Clear on reset or config change, otherwise step on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
        end else if (advance) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/iqmix_route.sv
// Decodes configuration and phase into the routing of the output pair.
// Assumes: complex mode only takes effect at the quarter rate.
module iqmix_route
    import iqmix_pkg::*;
(
    input  mix_cfg_t           cfg,
    input  logic [PHASE_W-1:0] phase,
    output route_e             route
);

    logic quarter;
    logic cplx;

    // Complex rotation applies only when the carrier is at a quarter rate.
    always_comb begin
        quarter = (cfg.rate == RATE_QTR) || (cfg.rate == RATE_QTR_B);
        cplx    = quarter && !cfg.real_mode;
    end

    // Pick the pair operation for the current phase.
    always_comb begin
        route = RT_PASS;
        if (cfg.rate == RATE_OFF) begin
            route = RT_PASS;
        end else if (cfg.rate == RATE_HALF) begin
            route = phase[0] ? RT_NEG : RT_PASS;
        end else if (cplx) begin
            unique case (phase)
                2'd0:    route = RT_PASS;
                2'd1:    route = cfg.flip ? RT_NQI : RT_QNI;
                2'd2:    route = RT_NEG;
                default: route = cfg.flip ? RT_QNI : RT_NQI;
            endcase
        end else begin
            if (phase[0]) route = RT_ZERO;
            else          route = phase[1] ? RT_NEG : RT_PASS;
        end
    end

endmodule

// File: rtl/iqmix_sat_neg.sv
// Saturating two's complement negation.
// Assumes: signed input of W bits; the most negative code maps to the
// most positive one instead of wrapping.
module iqmix_sat_neg #(
    parameter int W = 14
) (
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);

    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

    // Negate, clamping the single overflowing code.
    always_comb begin
        dout = (din == MIN_V) ? MAX_V : -din;
    end

endmodule

// File: rtl/iq_carrier_mixer.sv
// Multiplier-free IQ frequency shifter. Applies a +1/0/-1 carrier at the
// half or quarter input rate, in real or complex image-reject form.
// Assumes: one sample pair per in_valid; registered outputs with one clock
// latency; a sample accepted in a write cycle uses the old configuration.
module iq_carrier_mixer
    import iqmix_pkg::*;
#(
    parameter int DW = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_rate_in,
    input  logic                 cfg_real_in,
    input  logic                 cfg_flip_in,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);

    localparam int LANES = 2;

    mix_cfg_t           cfg_wdata;
    mix_cfg_t           cfg_q;
    logic               cfg_restart;
    logic [PHASE_W-1:0] phase_q;
    route_e             route;

    logic signed [DW-1:0] lane_in  [LANES];
    logic signed [DW-1:0] lane_neg [LANES];
    logic signed [DW-1:0] nxt_i;
    logic signed [DW-1:0] nxt_q;

    // Pack the configuration pins into the register word.
    always_comb begin
        cfg_wdata = '{rate: rate_e'(cfg_rate_in), real_mode: cfg_real_in, flip: cfg_flip_in};
    end

    iqmix_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .cfg_q   (cfg_q),
        .restart (cfg_restart)
    );

    iqmix_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_restart),
        .advance (in_valid),
        .phase_q (phase_q)
    );

    iqmix_route u_route (
        .cfg   (cfg_q),
        .phase (phase_q),
        .route (route)
    );

    // Present both channels to the lane negators.
    always_comb begin
        lane_in[0] = in_i;
        lane_in[1] = in_q;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        iqmix_sat_neg #(.W(DW)) u_neg (
            .din  (lane_in[k]),
            .dout (lane_neg[k])
        );
    end

    // Form the next output pair from the selected route.
    always_comb begin
        unique case (route)
            RT_NEG:  begin nxt_i = lane_neg[0]; nxt_q = lane_neg[1]; end
            RT_ZERO: begin nxt_i = '0;          nxt_q = '0;          end
            RT_QNI:  begin nxt_i = in_q;        nxt_q = lane_neg[0]; end
            RT_NQI:  begin nxt_i = lane_neg[1]; nxt_q = in_i;        end
            default: begin nxt_i = in_i;        nxt_q = in_q;        end
        endcase
    end

    // Register outputs; data holds while no sample is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= nxt_i;
                out_q <= nxt_q;
            end
        end
    end

endmodule

// File: rtl/iqmix_checker.sv
// Temporal checks on the IQ carrier mixer, bound to every instance.
module iqmix_checker
    import iqmix_pkg::*;
#(
    parameter int DW = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_i,
    input logic signed [DW-1:0] in_q,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_i,
    input logic signed [DW-1:0] out_q,
    input mix_cfg_t             cfg_q,
    input logic [PHASE_W-1:0]   phase_q,
    input logic                 restart
);

    localparam logic signed [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_i) && $stable(out_q)));
    p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !restart) |=> $stable(phase_q));
    p_phase_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !restart) |=> (phase_q == $past(phase_q) + 2'd1));
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0));
    p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_q.rate == RATE_OFF) |=> (out_i == $past(in_i) && out_q == $past(in_q)));
    p_zero_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_q.real_mode && cfg_q.rate[1] && phase_q[0]) |=> (out_i == '0 && out_q == '0));
    p_cplx_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_q.real_mode && cfg_q.rate[1] && phase_q == 2'd2 && in_i != MIN_V)
        |=> (out_i == -$past(in_i)));
    p_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_q.real_mode && cfg_q.rate == RATE_HALF && !phase_q[0])
        |=> (out_i == $past(in_i) && out_q == $past(in_q)));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_i != MIN_V && in_q != MIN_V) |=> (out_i != MIN_V && out_q != MIN_V));

endmodule

bind iq_carrier_mixer iqmix_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .cfg_q     (cfg_q),
    .phase_q   (phase_q),
    .restart   (cfg_restart)
);

// File: tb/iq_carrier_mixer_test.sv
// Scoreboard bench: the driver predicts each output pair from the
// requirements and queues it; the monitor pops and compares.
module iq_carrier_mixer_test;

    localparam logic signed [13:0] MINV = 14'h2000;
    localparam logic signed [13:0] MAXV = 14'h1FFF;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [1:0]         cfg_rate_in = 2'b00;
    logic               cfg_real_in = 1'b0;
    logic               cfg_flip_in = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [13:0] in_i = '0;
    logic signed [13:0] in_q = '0;
    logic               out_valid;
    logic signed [13:0] out_i;
    logic signed [13:0] out_q;

    iq_carrier_mixer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rate_in(cfg_rate_in),
        .cfg_real_in(cfg_real_in), .cfg_flip_in(cfg_flip_in), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit mon_en = 1'b0;

    logic signed [13:0] exp_i_q [$];
    logic signed [13:0] exp_q_q [$];
    string              tag_q   [$];
    logic signed [13:0] last_i = '0;
    logic signed [13:0] last_q = '0;

    // Reference state, reset defaults per R1
    logic [1:0] m_rate = 2'b10;
    logic       m_real = 1'b1;
    logic       m_flip = 1'b0;
    int         m_ph   = 0;

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic logic signed [13:0] nsat(logic signed [13:0] x);
        if (x == MINV) return MAXV;
        return -x;
    endfunction

    task automatic send(logic signed [13:0] i, logic signed [13:0] q, string tag);
        logic signed [13:0] ei, eq;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b1; in_i = i; in_q = q;
        if (m_rate == 2'b00) begin
            ei = i; eq = q;
        end else if (m_rate == 2'b01) begin
            if (m_ph % 2 == 1) begin ei = nsat(i); eq = nsat(q); end
            else begin ei = i; eq = q; end
        end else if (!m_real) begin
            case (m_ph)
                0: begin ei = i; eq = q; end
                1: if (m_flip) begin ei = nsat(q); eq = i; end
                   else begin ei = q; eq = nsat(i); end
                2: begin ei = nsat(i); eq = nsat(q); end
                default: if (m_flip) begin ei = q; eq = nsat(i); end
                         else begin ei = nsat(q); eq = i; end
            endcase
        end else begin
            case (m_ph)
                0: begin ei = i; eq = q; end
                2: begin ei = nsat(i); eq = nsat(q); end
                default: begin ei = '0; eq = '0; end
            endcase
        end
        m_ph = (m_ph + 1) % 4;
        exp_i_q.push_back(ei);
        exp_q_q.push_back(eq);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cfg_we = 1'b0; in_valid = 1'b0;
            in_i = 14'h1555; in_q = 14'h2AAA;   // junk that must be ignored (R9)
        end
    endtask

    task automatic setcfg(logic [1:0] r, logic re, logic f);
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b1;
        cfg_rate_in = r; cfg_real_in = re; cfg_flip_in = f;
        if (r != m_rate || re != m_real || f != m_flip) m_ph = 0;   // R10
        m_rate = r; m_real = re; m_flip = f;
    endtask

    // Monitor: compare each produced pair, and check hold on idle cycles.
    always @(negedge clk) begin
        if (mon_en) begin
            if (out_valid) begin
                if (exp_i_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected out_valid", 1, 0);
                end else begin
                    logic signed [13:0] ei, eq;
                    string t;
                    ei = exp_i_q.pop_front();
                    eq = exp_q_q.pop_front();
                    t  = tag_q.pop_front();
                    check(out_i == ei, t, "out_i", int'(out_i), int'(ei));
                    check(out_q == eq, t, "out_q", int'(out_q), int'(eq));
                end
                last_i = out_i; last_q = out_q;
            end else begin
                check(out_i == last_i && out_q == last_q, "R9", "hold out_i", int'(out_i), int'(last_i));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL R9 watchdog: got %0d cycles expected fewer than %0d", cyc, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(out_i == 0 && out_q == 0, "R1", "outputs in reset", int'(out_i), 0);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // R1 defaults: real quarter rate from phase 0
        send(14'sd100, -14'sd200, "R1");
        send(14'sd300, 14'sd400, "R1");
        send(14'sd500, -14'sd600, "R1");
        send(-14'sd700, 14'sd800, "R1");
        idle(2);

        // R2 pass-through, including extremes
        setcfg(2'b00, 1'b1, 1'b0);
        send(MINV, MAXV, "R2");
        send(14'sd1, -14'sd1, "R2");
        send(14'sd4321, -14'sd1234, "R2");

        // R3 half rate with idle gaps (R9: phase holds across gaps)
        setcfg(2'b01, 1'b1, 1'b0);
        send(14'sd1000, 14'sd2000, "R3");
        idle(3);
        send(14'sd1000, 14'sd2000, "R3");
        send(-14'sd50, 14'sd75, "R3");
        idle(1);
        send(14'sd9, 14'sd10, "R3");

        // R4 real quarter rate via code 11
        setcfg(2'b11, 1'b1, 1'b0);
        for (int k = 0; k < 8; k++) send(14'(k * 611 - 2000), 14'(1500 - k * 377), "R4");

        // R5 complex quarter rate, rotation 0
        setcfg(2'b10, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) send(14'(k * 97 + 11), 14'(-k * 53 - 7), "R5");

        // R6 complex quarter rate, rotation 1
        setcfg(2'b10, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) send(14'(k * 131 - 300), 14'(k * 29 + 5), "R6");

        // R7 complex request at half and zero rate falls back to real
        setcfg(2'b01, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) send(14'(k * 200 + 3), 14'(k * 100 - 9), "R7");
        setcfg(2'b00, 1'b0, 1'b0);
        for (int k = 0; k < 2; k++) send(14'(k * 55 + 1), 14'(-k * 66 - 2), "R7");

        // R8 saturation on every negating route
        setcfg(2'b10, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) send(MINV, MINV, "R8");
        setcfg(2'b01, 1'b1, 1'b0);
        send(MINV, MINV, "R8");
        send(MINV, MINV, "R8");
        setcfg(2'b10, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) send(MINV, MINV, "R8");

        // R10 same-value rewrite keeps phase; changed value restarts it
        setcfg(2'b10, 1'b0, 1'b0);
        send(14'sd10, 14'sd20, "R10");
        send(14'sd30, 14'sd40, "R10");
        setcfg(2'b10, 1'b0, 1'b0);
        send(14'sd50, 14'sd60, "R10");
        send(14'sd70, 14'sd80, "R10");
        send(14'sd90, 14'sd15, "R10");
        setcfg(2'b11, 1'b0, 1'b0);
        send(14'sd11, 14'sd22, "R10");
        send(14'sd33, 14'sd44, "R10");

        idle(4);
        check(exp_i_q.size() == 0, "R9", "pending results", exp_i_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule